// File: doc/BRIEF.md
# Timer Tick Interrupt Pacer

This block sits between a periodic timer tick and one or more interrupt controllers. Every tick adds to a backlog of ticks that have not yet been delivered. The block sends at most one interrupt request at a time. It does not send the next one until the consumer acknowledges the previous request, or until an optional timeout has run out. The block therefore never floods a slow consumer, and it never loses ticks that arrive while the consumer is busy.

An acknowledge carries a vector. The acknowledge counts only if that vector names an unmasked tick line on one of the attached controllers, and only while there is backlog to retire. A counted acknowledge takes one tick off the backlog, permits the next request, and sends a restart strobe so that the tick source can realign its timing reference. A pending flag stays high while the backlog is nonzero, so that an idle consumer can be woken. All outputs are registered.

Top module: `tick_irq_pacer`

## Requirements
- R1: While `rst` is high and in the first cycle after reset, the following hold: the backlog is 0, `pending_o` is 0, `irq_o` is all zero, `restart_o` is 0. Reset also sets the may-inject state, so the first tick is delivered without waiting for an acknowledge.
- R2: A `tick_i` sampled at a clock edge raises `backlog_o` by one after that edge. `pending_o` is 1 exactly when `backlog_o` is nonzero.
- R3: The backlog saturates at 2^CNT_W-1. A further tick at that value leaves it unchanged and does not wrap.
- R4: A request is decided in any cycle where the backlog is nonzero and may-inject is set. After that edge, every bit of `irq_o` is high for exactly one cycle and then low, and may-inject is cleared. No further request follows until a counted acknowledge or a timeout.
- R5: An acknowledge counts when `ack_valid_i` is high, the backlog is nonzero, and `ack_vec_i` equals `ctl_vec_i[c*VEC_W +: VEC_W]` for some controller c whose `ctl_mask_i[c]` is 0 (1 means masked). A counted acknowledge lowers the backlog by one and sets may-inject.
- R6: An acknowledge is ignored when its vector matches no controller, when the only matching controllers are masked, or when the backlog is zero. In each of these cases the backlog, `restart_o` and the request pacing are unaffected.
- R7: A counted acknowledge makes `restart_o` high for one cycle after the edge at which it was sampled.
- R8: When a tick and a counted acknowledge are sampled at the same edge, the backlog keeps its value.
- R9: An age counter restarts at 0 on each request and then counts cycles up to TIMEOUT, where it saturates. While `tmo_en_i` is high, an age of TIMEOUT with a nonzero backlog issues a request even if may-inject is clear. While `tmo_en_i` is low, no request is made this way.
- R10: When a request decision and a counted acknowledge fall on the same edge, the request wins: may-inject ends up cleared, and the backlog still drops by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timer tick strobe, one per period |
| ack_valid_i | input | 1 | Acknowledge strobe from the consumer |
| ack_vec_i | input | VEC_W | Vector carried with the acknowledge |
| ctl_mask_i | input | NCTRL | Tick-line mask per controller, 1 = masked |
| ctl_vec_i | input | NCTRL*VEC_W | Tick-line vector per controller, controller c at bits c*VEC_W upward |
| tmo_en_i | input | 1 | Enables the timeout fallback |
| irq_o | output | NCTRL | One-cycle request pulse, same on every controller |
| pending_o | output | 1 | Backlog is nonzero (wake-up hint) |
| backlog_o | output | CNT_W | Number of undelivered ticks |
| restart_o | output | 1 | One-cycle strobe after a counted acknowledge |

## Verification
Several of this block's functions can fall on the same edge. A tick can arrive together with a counted acknowledge, which has to leave the backlog flat. A request decision can coincide with an acknowledge, and then the cleared may-inject state has to win. The bench creates the first case by driving a tick and a matching acknowledge in one cycle while backlog remains. It creates the second by putting a single tick into an empty, may-inject state and driving a matching acknowledge on the very next cycle. Both cases are judged by the cycle-by-cycle model: the backlog has to stay put in the first case, and in the second no request may follow until the timeout or a later acknowledge.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_DEC  = 2'd2
  } backlog_op_e;

  function automatic backlog_op_e pick_op(input logic tick, input logic retire);
    if (tick && !retire)      return OP_INC;
    else if (retire && !tick) return OP_DEC;
    else                      return OP_HOLD;
  endfunction

endpackage

// File: rtl/pacer_ack_match.sv
module pacer_ack_match #(
  parameter int NCTRL = 2,
  parameter int VEC_W = 8
) (
  input  logic                   ack_valid_i,
  input  logic [VEC_W-1:0]       ack_vec_i,
  input  logic [NCTRL-1:0]       ctl_mask_i,
  input  logic [NCTRL*VEC_W-1:0] ctl_vec_i,
  output logic                   hit_o
);

  logic [NCTRL-1:0] line_hit;

  for (genvar c = 0; c < NCTRL; c++) begin : g_ctrl
    assign line_hit[c] = !ctl_mask_i[c] && (ack_vec_i == ctl_vec_i[c*VEC_W +: VEC_W]);
  end

  assign hit_o = ack_valid_i && (|line_hit);

endmodule

// File: rtl/pacer_backlog.sv
module pacer_backlog
  import pacer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  backlog_op_e      op_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q;

  always_comb begin
    cnt_d = cnt_q;
    case (op_i)
      OP_INC:  if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      OP_DEC:  cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= (cnt_d != '0);
    end
  end

  assign cnt_o  = cnt_q;
  assign busy_o = busy_q;

endmodule

// File: rtl/pacer_age.sv
module pacer_age #(
  parameter int TIMEOUT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  input  logic tmo_en_i,
  output logic expired_o
);

  localparam int AGE_W = $clog2(TIMEOUT + 1);
  localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(TIMEOUT);

  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst)                  age_q <= '0;
    else if (fire_i)          age_q <= '0;
    else if (age_q != AGE_LIM) age_q <= age_q + 1'b1;
  end

  assign expired_o = tmo_en_i && (age_q == AGE_LIM);

endmodule

// File: rtl/pacer_issue.sv
module pacer_issue #(
  parameter int NCTRL = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             backlog_nz_i,
  input  logic             ack_ok_i,
  input  logic             expired_i,
  output logic             fire_o,
  output logic [NCTRL-1:0] irq_o,
  output logic             restart_o
);

  logic             may_q;
  logic [NCTRL-1:0] irq_q;
  logic             restart_q;

  assign fire_o = backlog_nz_i && (may_q || expired_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      may_q     <= 1'b1;
      irq_q     <= '0;
      restart_q <= 1'b0;
    end else begin
      if (fire_o)        may_q <= 1'b0;
      else if (ack_ok_i) may_q <= 1'b1;
      irq_q     <= {NCTRL{fire_o}};
      restart_q <= ack_ok_i;
    end
  end

  assign irq_o     = irq_q;
  assign restart_o = restart_q;

endmodule

// File: rtl/tick_irq_pacer.sv
module tick_irq_pacer
  import pacer_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int VEC_W   = 8,
  parameter int NCTRL   = 2,
  parameter int TIMEOUT = 1000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick_i,
  input  logic                   ack_valid_i,
  input  logic [VEC_W-1:0]       ack_vec_i,
  input  logic [NCTRL-1:0]       ctl_mask_i,
  input  logic [NCTRL*VEC_W-1:0] ctl_vec_i,
  input  logic                   tmo_en_i,
  output logic [NCTRL-1:0]       irq_o,
  output logic                   pending_o,
  output logic [CNT_W-1:0]       backlog_o,
  output logic                   restart_o
);

  logic        ack_hit, ack_ok, fire, expired, backlog_nz;
  logic [CNT_W-1:0] cnt;
  backlog_op_e op;

  pacer_ack_match #(.NCTRL(NCTRL), .VEC_W(VEC_W)) u_match (
    .ack_valid_i (ack_valid_i),
    .ack_vec_i   (ack_vec_i),
    .ctl_mask_i  (ctl_mask_i),
    .ctl_vec_i   (ctl_vec_i),
    .hit_o       (ack_hit)
  );

  assign backlog_nz = (cnt != '0);
  assign ack_ok     = ack_hit && backlog_nz;
  assign op         = pick_op(tick_i, ack_ok);

  pacer_backlog #(.CNT_W(CNT_W)) u_backlog (
    .clk    (clk),
    .rst    (rst),
    .op_i   (op),
    .cnt_o  (cnt),
    .busy_o (pending_o)
  );

  pacer_age #(.TIMEOUT(TIMEOUT)) u_age (
    .clk       (clk),
    .rst       (rst),
    .fire_i    (fire),
    .tmo_en_i  (tmo_en_i),
    .expired_o (expired)
  );

  pacer_issue #(.NCTRL(NCTRL)) u_issue (
    .clk          (clk),
    .rst          (rst),
    .backlog_nz_i (backlog_nz),
    .ack_ok_i     (ack_ok),
    .expired_i    (expired),
    .fire_o       (fire),
    .irq_o        (irq_o),
    .restart_o    (restart_o)
  );

  assign backlog_o = cnt;

endmodule

// File: rtl/pacer_checker.sv
module pacer_checker #(
  parameter int CNT_W = 8,
  parameter int NCTRL = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [NCTRL-1:0] irq_o,
  input logic             pending_o,
  input logic [CNT_W-1:0] backlog_o,
  input logic             restart_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_pending_flag_r2: assert property (@(posedge clk) disable iff (rst)
    pending_o == (backlog_o != '0));

  p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
    (backlog_o == $past(backlog_o)) || (backlog_o == $past(backlog_o) + 1'b1) ||
    (backlog_o + 1'b1 == $past(backlog_o)));

  p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (backlog_o == CNT_MAX) |=> (backlog_o != '0));

  p_irq_single_r4: assert property (@(posedge clk) disable iff (rst)
    irq_o[0] |=> !irq_o[0]);

  p_irq_all_lines_r4: assert property (@(posedge clk) disable iff (rst)
    ($countones(irq_o) == 0) || ($countones(irq_o) == NCTRL));

  p_irq_needs_backlog_r4: assert property (@(posedge clk) disable iff (rst)
    irq_o[0] |-> ($past(backlog_o) != '0));

  p_restart_needs_backlog_r6: assert property (@(posedge clk) disable iff (rst)
    restart_o |-> ($past(backlog_o) != '0));

  p_restart_single_r7: assert property (@(posedge clk) disable iff (rst)
    restart_o |-> (backlog_o <= $past(backlog_o)));

endmodule

bind tick_irq_pacer pacer_checker #(.CNT_W(CNT_W), .NCTRL(NCTRL)) u_pacer_checker (
  .clk       (clk),
  .rst       (rst),
  .irq_o     (irq_o),
  .pending_o (pending_o),
  .backlog_o (backlog_o),
  .restart_o (restart_o)
);

// File: tb/test_tick_irq_pacer.sv
module test_tick_irq_pacer;

  localparam int CNT_W = 3, VEC_W = 8, NCTRL = 2, TMO = 20;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic tick = 1'b0, ackv = 1'b0, tmo_en = 1'b0;
  logic [VEC_W-1:0] ackvec = '0;
  logic [NCTRL-1:0] mask = '0;
  logic [NCTRL*VEC_W-1:0] cvec = {8'h30, 8'h20};
  logic [NCTRL-1:0] irq;
  logic pending, restart;
  logic [CNT_W-1:0] backlog;

  int compared = 0, mismatched = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference state
  int m_cnt = 0, m_age = 0;
  bit m_may = 1, e_irq = 0, e_restart = 0;

  always #5 clk = ~clk;

  tick_irq_pacer #(.CNT_W(CNT_W), .VEC_W(VEC_W), .NCTRL(NCTRL), .TIMEOUT(TMO)) i_tick_irq_pacer (
    .clk(clk), .rst(rst), .tick_i(tick), .ack_valid_i(ackv), .ack_vec_i(ackvec),
    .ctl_mask_i(mask), .ctl_vec_i(cvec), .tmo_en_i(tmo_en),
    .irq_o(irq), .pending_o(pending), .backlog_o(backlog), .restart_o(restart));

  task automatic chk(input string req, input int act, input int exp, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit hit, ok, fire;
    if (rst) begin
      m_cnt = 0; m_age = 0; m_may = 1; e_irq = 0; e_restart = 0;
    end else begin
      hit = ackv && ((!mask[0] && ackvec == cvec[7:0]) || (!mask[1] && ackvec == cvec[15:8]));
      ok = hit && (m_cnt != 0);
      fire = (m_cnt != 0) && (m_may || (tmo_en && m_age >= TMO));
      if (tick && !ok) m_cnt = (m_cnt == CMAX) ? CMAX : m_cnt + 1;
      else if (ok && !tick) m_cnt = m_cnt - 1;
      if (fire) m_may = 0; else if (ok) m_may = 1;
      m_age = fire ? 0 : ((m_age < TMO) ? m_age + 1 : TMO);
      e_irq = fire; e_restart = ok;
    end
    #2;
    if (!rst && !done) begin
      chk(cur_req, int'(backlog), m_cnt, "backlog");
      chk(cur_req, int'(pending), int'(m_cnt != 0), "pending");
      chk(cur_req, int'(irq), e_irq ? 3 : 0, "irq");
      chk(cur_req, int'(restart), int'(e_restart), "restart");
    end
  end

  task automatic step(input bit t, input bit a, input logic [VEC_W-1:0] v);
    @(negedge clk);
    tick = t; ackv = a; ackvec = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'(backlog), 0, "backlog in reset");
    chk("R1", int'(irq), 0, "irq in reset");
    rst = 1'b0;
    @(negedge clk);
    chk("R1", int'(pending), 0, "pending after reset");
    chk("R1", int'(restart), 0, "restart after reset");

    cur_req = "R4"; step(1, 0, 0); idle(2);
    cur_req = "R2"; step(1, 0, 0); step(1, 0, 0); step(1, 0, 0); idle(2);
    cur_req = "R5"; step(0, 1, 8'h20); idle(3);
    cur_req = "R7"; step(0, 1, 8'h20); idle(2);
    cur_req = "R6"; mask = 2'b01; step(0, 1, 8'h20); idle(1);
    step(0, 1, 8'h55); idle(1);
    cur_req = "R5"; step(0, 1, 8'h30); idle(2);
    mask = 2'b00;
    cur_req = "R8"; step(1, 1, 8'h20); step(1, 1, 8'h30); idle(2);
    cur_req = "R3"; for (int i = 0; i < 10; i++) step(1, 0, 0); idle(1);
    chk("R3", int'(backlog), CMAX, "saturated backlog");
    cur_req = "R9"; tmo_en = 1'b1; idle(50);
    tmo_en = 1'b0; idle(40);
    cur_req = "R6"; for (int i = 0; i < 12; i++) step(0, 1, 8'h20);
    idle(1);
    chk("R6", int'(backlog), 0, "backlog drained");
    step(0, 1, 8'h20); idle(2);
    cur_req = "R10"; step(1, 0, 0); step(0, 1, 8'h30); idle(2);
    step(1, 0, 0); idle(3);
    chk("R10", int'(backlog), 1, "backlog waiting after clash");
    tmo_en = 1'b1; idle(TMO + 4);
    idle(1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule